// File: doc/BRIEF.md
# I2C Master Command Queue Engine

This block is the byte-level sequencer of an I2C master. Command words are pushed into a transmit queue. Each word either writes one byte or asks for one byte to be read, and it can also ask for a stop condition once it finishes. The engine takes words from the head of the queue in order. It issues bus operations to a separate bit-level waveform generator through a request/done handshake: start, repeated start, byte write, byte read and stop. Bytes read from the target are placed in a receive queue.

A transfer opens with a start condition followed by the address byte. The read/write bit of that address byte comes from the first command. When the direction changes between consecutive commands, the engine sends a repeated start and a fresh address byte. It can be told to keep the bus instead of releasing it when the transmit queue runs dry. A target that does not acknowledge ends the transfer: the queue is flushed, a cause code is recorded and a stop is sent. A read is never issued while the receive queue is full. In that case the engine holds the clock line low until space frees up. Status flags report queue fill and bus ownership.

Top module: `i2cq_engine`

## Requirements
- R1: A command word is 10 bits. Bits 7:0 hold the data byte. Bit 8 set means read one byte, and the data bits are then ignored. Bit 8 clear means write the data byte. Bit 9 set means a stop follows once this command completes.
- R2: The first command taken while idle produces a start operation (code 0). It is followed by a write operation (code 2) whose byte is {target[6:0], bit 8 of that command}.
- R3: A write command produces a write operation that carries its data byte. A read command produces a read operation (code 3), and the returned byte enters the receive queue. Bytes leave the receive queue in the order they arrived.
- R4: A read operation sets op_nak to 1 when its command carries the stop flag, and to 0 otherwise.
- R5: After a command that carries the stop flag, a stop operation (code 4) is issued and the bus is released, so status bit 5 returns to 0.
- R6: When the transmit queue is empty and hold_stop is 1, no stop is issued and status bit 5 stays 1. Once hold_stop is cleared, a stop is issued.
- R7: On a change of direction with restart_en set, a repeated-start operation (code 1) is issued, followed by a new address byte. With restart_en clear, the transfer aborts with cause 3.
- R8: A NACK on the address byte aborts the transfer with cause 1. A NACK on a data write aborts it with cause 2. On either abort the transmit queue is flushed and a stop is issued next. The cause is cleared when the next start is issued.
- R9: A read command that meets a full receive queue issues no read operation and drives scl_hold to 1 until an entry is popped.
- R10: status holds act (bit 0), transmit not full (1), transmit empty (2), receive not empty (3), receive full (4) and bus owned (5). act is bus owned OR transmit not empty.
- R11: tgt_load takes effect only while the engine is idle and the transmit queue is empty. At any other time it is ignored.
- R12: A push into a full transmit queue is ignored. Each queue holds the number of entries its depth parameter gives.
- R13: Once op_valid is raised, op_valid, op_code and op_wdata stay unchanged until op_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | 1 | Push cmd_word into the transmit queue |
| cmd_word | input | 10 | Command word: stop flag, read flag, data byte |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue (show-ahead) |
| hold_stop | input | 1 | Keep the bus when the transmit queue is empty |
| restart_en | input | 1 | Allow a repeated start on a change of direction |
| tgt_load | input | 1 | Load a new target address |
| tgt_addr | input | 7 | Target address to load |
| status | output | 6 | Queue and bus flags |
| abort_cause | output | 2 | 0 none, 1 address NACK, 2 data NACK, 3 restart needed but disabled |
| scl_hold | output | 1 | Read is waiting on a full receive queue; clock held low |
| op_valid | output | 1 | Bus operation requested |
| op_code | output | 3 | 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 stop |
| op_wdata | output | 8 | Byte to write |
| op_nak | output | 1 | Answer the read byte with NACK |
| op_done | input | 1 | Bit-level engine finished the operation |
| op_rx_nak | input | 1 | Target did not acknowledge the written byte |
| op_rdata | input | 8 | Byte received by a read operation |

## Verification
The bench builds the engine with both queues 16 entries deep. At that depth the transmit queue can be filled past its limit with a slow responder, and the receive queue can be filled by sixteen queued reads within a few hundred cycles. This brings the push-while-full case and the read stall on a full receive queue within reach. A bus responder model in the bench logs every operation, injects a NACK at a chosen operation index and checks that each request is held until it is answered.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    localparam int BYTE_W  = 8;
    localparam int TGT_W   = 7;
    localparam int CMD_W   = BYTE_W + 2;
    localparam int STAT_W  = 6;
    localparam int OPC_W   = 3;

    localparam int SB_ACT  = 0;
    localparam int SB_TXNF = 1;
    localparam int SB_TXE  = 2;
    localparam int SB_RXNE = 3;
    localparam int SB_RXF  = 4;
    localparam int SB_BUS  = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {
        AB_NONE       = 2'd0,
        AB_ADDR_NAK   = 2'd1,
        AB_DATA_NAK   = 2'd2,
        AB_NO_RESTART = 2'd3
    } abort_e;

    typedef struct packed {
        logic              stop;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_ADDR,
        SQ_PICK,
        SQ_STALL,
        SQ_WR,
        SQ_RD,
        SQ_RESTART,
        SQ_STOP
    } seq_e;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [TGT_W-1:0] a,
                                                    input logic rd);
        return {a, rd};
    endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push)
                wptr <= wptr + AW'(1);
            if (do_pop)
                rptr <= rptr + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (cnt == $past(cnt))); // R12
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty); // R8

endmodule

// File: rtl/i2cq_status.sv
module i2cq_status
    import i2cq_pkg::*;
(
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              bus_owned,
    output logic [STAT_W-1:0] status
);
    always_comb begin
        status          = '0;
        status[SB_BUS]  = bus_owned;
        status[SB_ACT]  = bus_owned || !tx_empty;
        status[SB_TXNF] = !tx_full;
        status[SB_TXE]  = tx_empty;
        status[SB_RXNE] = !rx_empty;
        status[SB_RXF]  = rx_full;
    end
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              tx_head,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              tx_flush,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_wdata,
    input  logic              hold_stop,
    input  logic              restart_en,
    input  logic              tgt_load,
    input  logic [TGT_W-1:0]  tgt_addr,
    output logic              op_valid,
    output bus_op_e           op_code,
    output logic [BYTE_W-1:0] op_wdata,
    output logic              op_nak,
    input  logic              op_done,
    input  logic              op_rx_nak,
    input  logic [BYTE_W-1:0] op_rdata,
    output abort_e            abort_cause,
    output logic              scl_hold,
    output logic              bus_owned
);
    seq_e             st, st_nx;
    logic             dir_q, dir_nx;
    abort_e           cause_q, cause_nx;
    logic [TGT_W-1:0] tgt_q;

    always_comb begin
        st_nx    = st;
        dir_nx   = dir_q;
        cause_nx = cause_q;
        tx_pop   = 1'b0;
        tx_flush = 1'b0;
        rx_push  = 1'b0;
        case (st)
            SQ_IDLE: begin
                if (!tx_empty) begin
                    st_nx    = SQ_START;
                    dir_nx   = tx_head.rd;
                    cause_nx = AB_NONE;
                end
            end
            SQ_START, SQ_RESTART: begin
                if (op_done)
                    st_nx = SQ_ADDR;
            end
            SQ_ADDR: begin
                if (op_done) begin
                    if (op_rx_nak) begin
                        cause_nx = AB_ADDR_NAK;
                        tx_flush = 1'b1;
                        st_nx    = SQ_STOP;
                    end else begin
                        st_nx = SQ_PICK;
                    end
                end
            end
            SQ_PICK: begin
                if (tx_empty) begin
                    if (!hold_stop)
                        st_nx = SQ_STOP;
                end else if (tx_head.rd != dir_q) begin
                    if (restart_en) begin
                        st_nx  = SQ_RESTART;
                        dir_nx = tx_head.rd;
                    end else begin
                        cause_nx = AB_NO_RESTART;
                        tx_flush = 1'b1;
                        st_nx    = SQ_STOP;
                    end
                end else if (tx_head.rd) begin
                    st_nx = rx_full ? SQ_STALL : SQ_RD;
                end else begin
                    st_nx = SQ_WR;
                end
            end
            SQ_STALL: begin
                if (!rx_full)
                    st_nx = SQ_RD;
            end
            SQ_WR: begin
                if (op_done) begin
                    if (op_rx_nak) begin
                        cause_nx = AB_DATA_NAK;
                        tx_flush = 1'b1;
                        st_nx    = SQ_STOP;
                    end else begin
                        tx_pop = 1'b1;
                        st_nx  = tx_head.stop ? SQ_STOP : SQ_PICK;
                    end
                end
            end
            SQ_RD: begin
                if (op_done) begin
                    rx_push = 1'b1;
                    tx_pop  = 1'b1;
                    st_nx   = tx_head.stop ? SQ_STOP : SQ_PICK;
                end
            end
            SQ_STOP: begin
                if (op_done)
                    st_nx = SQ_IDLE;
            end
            default: st_nx = SQ_IDLE;
        endcase
    end

    always_comb begin
        op_valid = 1'b1;
        op_code  = OP_WRITE;
        op_wdata = '0;
        op_nak   = 1'b0;
        case (st)
            SQ_START:   op_code  = OP_START;
            SQ_RESTART: op_code  = OP_RESTART;
            SQ_ADDR:    op_wdata = addr_byte(tgt_q, dir_q);
            SQ_WR:      op_wdata = tx_head.data;
            SQ_RD: begin
                op_code = OP_READ;
                op_nak  = tx_head.stop;
            end
            SQ_STOP:    op_code  = OP_STOP;
            default:    op_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            dir_q   <= 1'b0;
            cause_q <= AB_NONE;
            tgt_q   <= '0;
        end else begin
            st      <= st_nx;
            dir_q   <= dir_nx;
            cause_q <= cause_nx;
            if (tgt_load && st == SQ_IDLE && tx_empty)
                tgt_q <= tgt_addr;
        end
    end

    assign rx_wdata    = op_rdata;
    assign abort_cause = cause_q;
    assign scl_hold    = (st == SQ_STALL);
    assign bus_owned   = (st != SQ_IDLE);

    AST_OP_HELD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_done) |=> (op_valid && $stable(op_code) && $stable(op_wdata))); // R13
    AST_NO_READ_INTO_FULL: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_READ) |-> !rx_full); // R9
    AST_TGT_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgt_q) |-> ($past(st) == SQ_IDLE && $past(tx_empty))); // R11
    AST_NAK_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_WRITE && op_done && op_rx_nak) |=> (abort_cause != AB_NONE)); // R8
    AST_FLUSH_THEN_STOP: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (op_valid && op_code == OP_STOP)); // R8

endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
    import i2cq_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_push,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              hold_stop,
    input  logic              restart_en,
    input  logic              tgt_load,
    input  logic [TGT_W-1:0]  tgt_addr,
    output logic [STAT_W-1:0] status,
    output logic [1:0]        abort_cause,
    output logic              scl_hold,
    output logic              op_valid,
    output logic [OPC_W-1:0]  op_code,
    output logic [BYTE_W-1:0] op_wdata,
    output logic              op_nak,
    input  logic              op_done,
    input  logic              op_rx_nak,
    input  logic [BYTE_W-1:0] op_rdata
);
    cmd_t              tx_head;
    logic              tx_full, tx_empty, tx_pop, tx_flush;
    logic              rx_full, rx_empty, rx_push;
    logic [BYTE_W-1:0] rx_wdata;
    logic              bus_owned;
    bus_op_e           op_code_e;
    abort_e            cause_e;

    i2cq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .push  (cmd_push),
        .wdata (cmd_word),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    i2cq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (1'b0),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    i2cq_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .tx_head     (tx_head),
        .tx_empty    (tx_empty),
        .tx_pop      (tx_pop),
        .tx_flush    (tx_flush),
        .rx_full     (rx_full),
        .rx_push     (rx_push),
        .rx_wdata    (rx_wdata),
        .hold_stop   (hold_stop),
        .restart_en  (restart_en),
        .tgt_load    (tgt_load),
        .tgt_addr    (tgt_addr),
        .op_valid    (op_valid),
        .op_code     (op_code_e),
        .op_wdata    (op_wdata),
        .op_nak      (op_nak),
        .op_done     (op_done),
        .op_rx_nak   (op_rx_nak),
        .op_rdata    (op_rdata),
        .abort_cause (cause_e),
        .scl_hold    (scl_hold),
        .bus_owned   (bus_owned)
    );

    i2cq_status u_stat (
        .tx_full   (tx_full),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full),
        .rx_empty  (rx_empty),
        .bus_owned (bus_owned),
        .status    (status)
    );

    assign op_code     = op_code_e;
    assign abort_cause = cause_e;

endmodule

// File: tb/sim_i2cq_engine.sv
module sim_i2cq_engine;

    localparam int B_ACT = 0, B_TXNF = 1, B_TXE = 2, B_RXNE = 3, B_RXF = 4, B_BUS = 5;
    localparam logic [2:0] C_START = 3'd0, C_RESTART = 3'd1, C_WRITE = 3'd2,
                           C_READ = 3'd3, C_STOP = 3'd4;

    // {tgt[6:0], cmd[9:0], addr byte[7:0], op code[2:0], op data[7:0], op_nak}
    localparam int VN = 6;
    localparam logic [36:0] VEC [VN] = '{
        {7'h2A, 10'h23C, 8'h54, 3'd2, 8'h3C, 1'b0},
        {7'h51, 10'h300, 8'hA3, 3'd3, 8'h00, 1'b1},
        {7'h7F, 10'h2FF, 8'hFE, 3'd2, 8'hFF, 1'b0},
        {7'h00, 10'h200, 8'h00, 3'd2, 8'h00, 1'b0},
        {7'h13, 10'h3AB, 8'h27, 3'd3, 8'h00, 1'b1},
        {7'h40, 10'h281, 8'h80, 3'd2, 8'h81, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_push = 1'b0;
    logic [9:0] cmd_word = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       hold_stop = 1'b0;
    logic       restart_en = 1'b1;
    logic       tgt_load = 1'b0;
    logic [6:0] tgt_addr = '0;
    logic [5:0] status;
    logic [1:0] abort_cause;
    logic       scl_hold;
    logic       op_valid;
    logic [2:0] op_code;
    logic [7:0] op_wdata;
    logic       op_nak;
    logic       op_done = 1'b0;
    logic       op_rx_nak = 1'b0;
    logic [7:0] op_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    // responder model state
    int resp_delay = 2;
    int nak_at = -1;
    int op_n = 0;
    int rd_n = 0;
    int cnt = 0;
    logic [2:0] cap_code;
    logic [7:0] cap_data;
    logic       hs_bad = 1'b0;
    logic [2:0] log_code [1024];
    logic [7:0] log_data [1024];
    logic       log_nak  [1024];

    always #4 clk = ~clk;

    i2cq_engine u0 (
        .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_word(cmd_word),
        .rx_pop(rx_pop), .rx_data(rx_data), .hold_stop(hold_stop),
        .restart_en(restart_en), .tgt_load(tgt_load), .tgt_addr(tgt_addr),
        .status(status), .abort_cause(abort_cause), .scl_hold(scl_hold),
        .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
        .op_nak(op_nak), .op_done(op_done), .op_rx_nak(op_rx_nak),
        .op_rdata(op_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            op_done <= 1'b0;
            cnt     <= 0;
        end else if (op_done) begin
            op_done <= 1'b0;
            cnt     <= 0;
        end else if (op_valid) begin
            if (cnt == 0) begin
                cap_code <= op_code;
                cap_data <= op_wdata;
            end else if (op_code != cap_code || op_wdata != cap_data) begin
                hs_bad <= 1'b1;
            end
            if (cnt >= resp_delay) begin
                op_done   <= 1'b1;
                op_rx_nak <= (op_n == nak_at);
                op_rdata  <= 8'h50 + rd_n[7:0];
                log_code[op_n[9:0]] <= op_code;
                log_data[op_n[9:0]] <= op_wdata;
                log_nak[op_n[9:0]]  <= op_nak;
                op_n <= op_n + 1;
                if (op_code == C_READ)
                    rd_n <= rd_n + 1;
            end else begin
                cnt <= cnt + 1;
            end
        end else if (cnt != 0) begin
            hs_bad <= 1'b1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_op(input string req, input int idx,
                          input logic [2:0] code, input logic [7:0] data);
        chk(req, $sformatf("op %0d code", idx), 32'(log_code[idx]), 32'(code));
        chk(req, $sformatf("op %0d data", idx), 32'(log_data[idx]), 32'(data));
    endtask

    task automatic push(input logic [9:0] w);
        @(negedge clk);
        cmd_push = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    task automatic load_tgt(input logic [6:0] a);
        @(negedge clk);
        tgt_load = 1'b1;
        tgt_addr = a;
        @(negedge clk);
        tgt_load = 1'b0;
    endtask

    task automatic pop_rx(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, "rx byte", 32'(rx_data), 32'(exp));
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (!status[B_ACT]) break;
        end
    endtask

    task automatic wait_ops(input int n);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (op_n >= n) break;
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int b;
        int rb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state, R10
        chk("R10", "reset status", 32'(status), 32'h06);
        chk("R8", "reset abort", 32'(abort_cause), 32'h0);
        chk("R13", "reset op_valid", 32'(op_valid), 32'h0);
        chk("R9", "reset scl_hold", 32'(scl_hold), 32'h0);

        // table of single-command transfers: R1 R2 R3 R4 R5
        for (int v = 0; v < VN; v++) begin
            b  = op_n;
            rb = rd_n;
            load_tgt(VEC[v][36:30]);
            push(VEC[v][29:20]);
            wait_idle();
            chk("R2", "op count", 32'(op_n - b), 32'd4);
            chk_op("R2", b, C_START, 8'h00);
            chk_op("R2", b + 1, C_WRITE, VEC[v][19:12]);
            chk_op("R1", b + 2, VEC[v][11:9], VEC[v][8:1]);
            chk("R4", "read nak", 32'(log_nak[b + 2]), 32'(VEC[v][0]));
            chk_op("R5", b + 3, C_STOP, 8'h00);
            chk("R5", "status after stop", 32'(status), 32'(VEC[v][0] ? 6'h0E : 6'h06));
            if (VEC[v][11:9] == C_READ)
                pop_rx("R3", 8'h50 + rb[7:0]);
        end

        // write then reads with repeated start: R7 R3 R4
        hold_stop  = 1'b1;
        restart_en = 1'b1;
        load_tgt(7'h21);
        b  = op_n;
        rb = rd_n;
        push(10'h011);
        push(10'h100);
        push(10'h300);
        wait_idle();
        chk("R7", "op count", 32'(op_n - b), 32'd8);
        chk_op("R2", b + 1, C_WRITE, 8'h42);
        chk_op("R3", b + 2, C_WRITE, 8'h11);
        chk_op("R7", b + 3, C_RESTART, 8'h00);
        chk_op("R7", b + 4, C_WRITE, 8'h43);
        chk_op("R3", b + 5, C_READ, 8'h00);
        chk("R4", "first read ack", 32'(log_nak[b + 5]), 32'h0);
        chk("R4", "last read nak", 32'(log_nak[b + 6]), 32'h1);
        chk_op("R5", b + 7, C_STOP, 8'h00);
        pop_rx("R3", 8'h50 + rb[7:0]);
        pop_rx("R3", 8'h51 + rb[7:0]);

        // restart disabled: R7
        restart_en = 1'b0;
        b = op_n;
        push(10'h022);
        push(10'h300);
        wait_idle();
        chk("R7", "op count no restart", 32'(op_n - b), 32'd4);
        chk_op("R7", b + 3, C_STOP, 8'h00);
        chk("R7", "abort cause", 32'(abort_cause), 32'h3);
        chk("R7", "rx empty", 32'(status[B_RXNE]), 32'h0);
        restart_en = 1'b1;

        // stop hold: R6
        b = op_n;
        push(10'h033);
        wait_ops(b + 3);
        chk("R6", "ops while holding", 32'(op_n - b), 32'd3);
        chk("R6", "status holding", 32'(status), 32'h27);
        chk("R8", "abort cleared by start", 32'(abort_cause), 32'h0);
        hold_stop = 1'b0;
        wait_idle();
        chk_op("R6", b + 3, C_STOP, 8'h00);
        chk("R6", "bus released", 32'(status[B_BUS]), 32'h0);
        hold_stop = 1'b1;

        // address NACK: R8
        b = op_n;
        nak_at = b + 1;
        push(10'h044);
        push(10'h255);
        wait_idle();
        chk("R8", "op count addr nak", 32'(op_n - b), 32'd3);
        chk_op("R8", b + 2, C_STOP, 8'h00);
        chk("R8", "addr nak cause", 32'(abort_cause), 32'h1);
        chk("R8", "tx flushed", 32'(status[B_TXE]), 32'h1);

        // data NACK: R8
        b = op_n;
        nak_at = b + 2;
        push(10'h066);
        push(10'h077);
        push(10'h288);
        wait_idle();
        chk("R8", "op count data nak", 32'(op_n - b), 32'd4);
        chk_op("R8", b + 2, C_WRITE, 8'h66);
        chk_op("R8", b + 3, C_STOP, 8'h00);
        chk("R8", "data nak cause", 32'(abort_cause), 32'h2);
        nak_at = -1;

        // receive queue full stall: R9 R3
        rb = rd_n;
        for (int i = 0; i < 16; i++)
            push(10'h100);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (status[B_RXF] && status[B_TXE]) break;
        end
        repeat (10) @(negedge clk);
        chk("R9", "rx full flag", 32'(status[B_RXF]), 32'h1);
        b = op_n;
        push(10'h300);
        repeat (20) @(negedge clk);
        chk("R9", "scl held", 32'(scl_hold), 32'h1);
        chk("R9", "no read issued", 32'(op_n - b), 32'd0);
        pop_rx("R9", 8'h50 + rb[7:0]);
        wait_idle();
        chk("R9", "scl released", 32'(scl_hold), 32'h0);
        chk_op("R9", b, C_READ, 8'h00);
        chk("R4", "stall read nak", 32'(log_nak[b]), 32'h1);
        chk_op("R5", b + 1, C_STOP, 8'h00);
        for (int i = 1; i <= 16; i++)
            pop_rx("R3", 8'h50 + rb[7:0] + 8'(i));
        chk("R10", "rx drained", 32'(status), 32'h06);

        // target load while busy is ignored: R11
        resp_delay = 40;
        load_tgt(7'h10);
        b = op_n;
        push(10'h299);
        repeat (10) @(negedge clk);
        load_tgt(7'h6E);
        wait_idle();
        resp_delay = 2;
        push(10'h2AA);
        wait_idle();
        chk_op("R11", b + 1, C_WRITE, 8'h20);
        chk_op("R11", b + 5, C_WRITE, 8'h20);

        // transmit queue full: R12
        resp_delay = 60;
        b = op_n;
        for (int i = 1; i <= 16; i++)
            push((i == 16) ? 10'h210 : 10'(i));
        @(negedge clk);
        chk("R12", "tx not-full flag", 32'(status[B_TXNF]), 32'h0);
        chk("R10", "tx empty flag", 32'(status[B_TXE]), 32'h0);
        push(10'h2EE);
        wait_idle();
        resp_delay = 2;
        chk("R12", "op count full", 32'(op_n - b), 32'd19);
        chk_op("R12", b + 17, C_WRITE, 8'h10);
        chk_op("R12", b + 18, C_STOP, 8'h00);

        // handshake held throughout: R13
        chk("R13", "op held until done", 32'(hs_bad), 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule